// File: doc/BRIEF.md
# Configuration Image Byte Loader

This controller copies a programmable-logic configuration image from a byte-addressed source memory into a byte-wide configuration port. A start pulse begins a load. The controller first writes zero to the interrupt control to mask it. It then checks that the image is large enough to hold a header, pulses a reset strobe at the target and waits a settle delay. Next it writes one zero byte to the configuration port and waits again.

After that it reads a 16-byte header. The header's first four bytes hold the payload length, and the other twelve bytes are not interpreted. The controller streams that many payload bytes, taken from image offset 16 upward, and follows them with five zero padding bytes. It then samples the target's error indication in the interrupt status. On success it waits one more settle delay, writes the enable code 0x43 to the interrupt control and raises done. On any failure it raises fail and leaves the interrupt control at zero.

The source memory is synchronous: data requested in one cycle is presented in the next cycle. Each payload byte therefore takes two cycles.

Top module: `cfg_image_loader`

## Requirements
- R1: A start pulse while idle makes busy high and causes a write of 0x00 to the interrupt control as the first action. A start pulse while busy is ignored: it causes no second 0x00 write and does not change the sequence of port writes.
- R2: When the image is at least 16 bytes, a one-cycle target reset strobe is issued. The single zero byte is written to the configuration port exactly SETTLE+1 cycles after that strobe.
- R3: An image_size below 16 ends the load with fail high. There is no target reset strobe and no configuration port write.
- R4: The payload length is the 32-bit big-endian value of image bytes 0 to 3, with byte 0 as the most significant byte. Image bytes 4 to 15 do not affect the load.
- R5: Payload bytes are read from image offsets 16, 17 and upward. Exactly length of them are written to the configuration port, in address order, after the initial zero byte.
- R6: Exactly five 0x00 padding bytes follow the last payload byte on the configuration port.
- R7: If 16 + length exceeds image_size, the load ends with fail high after the initial zero byte. No payload byte, no padding byte and no 0x43 write is issued.
- R8: If bit 5 of irq_status is set when the controller samples it after the padding, the load ends with fail high and no further interrupt control write. The other status bits have no effect on the result.
- R9: On success, 0x43 is written to the interrupt control exactly SETTLE+2 cycles after the last padding byte. Done rises in the following cycle and busy falls at the same time.
- R10: A length of zero produces no payload writes: the initial zero byte is followed directly by the five padding bytes, and the load succeeds.
- R11: Done and fail hold their values while the controller is idle and are both cleared by the next accepted start.
- R12: After reset, busy, done and fail are low and no strobe output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| image_size | input | AW | Number of valid image bytes in the source memory |
| mem_rd | output | 1 | Read request to the source memory |
| mem_addr | output | AW | Byte address of the read |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| cfg_wr | output | 1 | Configuration port write strobe |
| cfg_data | output | 8 | Configuration port write byte |
| tgt_reset | output | 1 | Target reset strobe (one dummy access) |
| irq_status | input | 8 | Target interrupt status; bit 5 flags a load error |
| irq_ctrl_wr | output | 1 | Interrupt control write strobe |
| irq_ctrl_data | output | 8 | Interrupt control value (0x00 mask, 0x43 enable) |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load succeeded |
| fail | output | 1 | Last load failed |

## Verification
The embedded properties assume that image_size stays constant from the accepted start until busy falls. They also assume that the memory returns data one cycle after each read. The read-address bound rests on both assumptions. The bench changes image_size only between loads, while the controller is idle. It models the memory as a registered array, so read data arrives in the cycle after the request. The bench sweeps the payload length across an exact fit and a fit one byte too short. It also covers every undersized image, lengths with nonzero upper header bytes, and error and non-error status patterns.

// File: rtl/cfg_image_loader.sv
module cfg_image_loader #(
  parameter int AW     = 16,
  parameter int SETTLE = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] image_size,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          cfg_wr,
  output logic [7:0]    cfg_data,
  output logic          tgt_reset,
  input  logic [7:0]    irq_status,
  output logic          irq_ctrl_wr,
  output logic [7:0]    irq_ctrl_data,
  output logic          busy,
  output logic          done,
  output logic          fail
);
  localparam int         HDR     = 16;
  localparam int         NPAD    = 5;
  localparam int         ERR_BIT = 5;
  localparam logic [7:0] IE_CODE = 8'h43;
  localparam int         WW      = $clog2(SETTLE + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_IEOFF, S_RST, S_W1, S_ZB, S_W2, S_HRD, S_HCAP,
    S_LCHK, S_PRD, S_PWR, S_PAD, S_STAT, S_W3, S_IEON
  } st_t;

  st_t           st;
  logic [WW-1:0] wcnt;
  logic [AW-1:0] ptr;
  logic [31:0]   len, rem;
  logic [1:0]    hcnt;
  logic [2:0]    pcnt;
  logic          wait_end;

  assign wait_end      = (wcnt == WW'(SETTLE - 1));
  assign busy          = (st != S_IDLE);
  assign tgt_reset     = (st == S_RST);
  assign irq_ctrl_wr   = (st == S_IEOFF) || (st == S_IEON);
  assign irq_ctrl_data = (st == S_IEON) ? IE_CODE : 8'h00;
  assign cfg_wr        = (st == S_ZB) || (st == S_PWR) || (st == S_PAD);
  assign cfg_data      = (st == S_PWR) ? mem_rdata : 8'h00;
  assign mem_rd        = (st == S_HRD) || (st == S_PRD);
  assign mem_addr      = (st == S_HRD) ? AW'(hcnt) : ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      wcnt <= '0;
      ptr  <= '0;
      len  <= '0;
      rem  <= '0;
      hcnt <= '0;
      pcnt <= '0;
      done <= 1'b0;
      fail <= 1'b0;
    end else begin
      if (st == S_W1 || st == S_W2 || st == S_W3)
        wcnt <= wait_end ? '0 : wcnt + 1'b1;
      else
        wcnt <= '0;
      case (st)
        S_IDLE: if (start) begin
          done <= 1'b0;
          fail <= 1'b0;
          st   <= S_IEOFF;
        end
        S_IEOFF: if (image_size < AW'(HDR)) begin
          fail <= 1'b1;
          st   <= S_IDLE;
        end else st <= S_RST;
        S_RST: st <= S_W1;
        S_W1:  if (wait_end) st <= S_ZB;
        S_ZB:  st <= S_W2;
        S_W2:  if (wait_end) begin
          hcnt <= '0;
          len  <= '0;
          st   <= S_HRD;
        end
        S_HRD:  st <= S_HCAP;
        S_HCAP: begin
          len  <= {len[23:0], mem_rdata};
          hcnt <= hcnt + 1'b1;
          st   <= (hcnt == 2'd3) ? S_LCHK : S_HRD;
        end
        S_LCHK: if (({1'b0, len} + 33'(HDR)) > 33'(image_size)) begin
          fail <= 1'b1;
          st   <= S_IDLE;
        end else begin
          rem  <= len;
          ptr  <= AW'(HDR);
          pcnt <= '0;
          st   <= (len == 32'd0) ? S_PAD : S_PRD;
        end
        S_PRD: st <= S_PWR;
        S_PWR: begin
          ptr <= ptr + 1'b1;
          rem <= rem - 1'b1;
          st  <= (rem == 32'd1) ? S_PAD : S_PRD;
        end
        S_PAD: begin
          pcnt <= pcnt + 1'b1;
          if (pcnt == 3'(NPAD - 1)) st <= S_STAT;
        end
        S_STAT: if (irq_status[ERR_BIT]) begin
          fail <= 1'b1;
          st   <= S_IDLE;
        end else st <= S_W3;
        S_W3:   if (wait_end) st <= S_IEON;
        S_IEON: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: the first cycle of every load masks the interrupt control
  assert_first_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (irq_ctrl_wr && irq_ctrl_data == 8'h00));

  // R2: the settle delay follows the reset strobe, not a port write
  assert_settle_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_reset |=> !cfg_wr);

  // R7: reads never go past the image (image_size held during a load)
  assert_read_in_image_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr < image_size));

  // R9: the enable write completes a successful load
  assert_enable_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ctrl_wr && irq_ctrl_data == IE_CODE) |=> (done && !fail && !busy));

  // R11: the two result flags are never both set
  assert_result_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R12: an idle controller drives no port strobe
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(cfg_wr || mem_rd || tgt_reset || irq_ctrl_wr));
endmodule

// File: tb/sim_cfg_image_loader.sv
module sim_cfg_image_loader;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int ST = 3;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] image_size = '0;
  logic mem_rd, cfg_wr, tgt_reset, irq_ctrl_wr, busy, done, fail;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = '0, cfg_data, irq_status = '0, irq_ctrl_data;

  cfg_image_loader #(.AW(AW), .SETTLE(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .image_size(image_size),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .cfg_wr(cfg_wr), .cfg_data(cfg_data), .tgt_reset(tgt_reset),
    .irq_status(irq_status), .irq_ctrl_wr(irq_ctrl_wr),
    .irq_ctrl_data(irq_ctrl_data), .busy(busy), .done(done), .fail(fail));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] mem [0:255];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  int checks = 0, errors = 0, cyc = 0;
  int wlog [0:511]; int wcyc [0:511]; int nw = 0;
  int ilog [0:7];   int icyc [0:7];   int ni = 0;
  int rcyc = 0; int nr = 0;
  bit mon_on = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (mon_on) begin
    if (cfg_wr) begin wlog[nw] = cfg_data; wcyc[nw] = cyc; nw++; end
    if (irq_ctrl_wr && ni < 8) begin ilog[ni] = irq_ctrl_data; icyc[ni] = cyc; ni++; end
    if (tgt_reset) begin rcyc = cyc; nr++; end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(int i, int len);
    return 8'((i * 37 + len * 5 + 11) & 255);
  endfunction

  task automatic load(int img, int len, bit err, bit mid_start);
    bit ok_size, ok_len, ok;
    int np, tmo;
    mem[0] = 8'(len >> 24); mem[1] = 8'(len >> 16);
    mem[2] = 8'(len >> 8);  mem[3] = 8'(len);
    for (int k = 4; k < 16; k++) mem[k] = 8'(8'hA5 ^ k);
    for (int k = 16; k < 256; k++) mem[k] = pay(k - 16, len);
    image_size = AW'(img);
    irq_status = err ? 8'h20 : 8'hDF;
    nw = 0; ni = 0; nr = 0; mon_on = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1, "R1 busy after start", busy, 1);
    tmo = 0;
    while (busy && tmo < 3000) begin
      @(negedge clk); tmo++;
      if (mid_start && tmo == 8) start = 1;
      if (mid_start && tmo == 9) start = 0;
    end
    mon_on = 0;
    chk(tmo < 3000, "R1 watchdog", tmo, 0);
    ok_size = img >= 16;
    ok_len  = ok_size && (longint'(len) + 16 <= longint'(img));
    ok      = ok_len && !err;
    np      = ok_len ? len : 0;
    chk(ni >= 1 && ilog[0] == 0, "R1 first irq write 0x00", ni >= 1 ? ilog[0] : -1, 0);
    chk(nr == (ok_size ? 1 : 0), "R3 reset strobe count", nr, ok_size ? 1 : 0);
    chk(nw == (!ok_size ? 0 : (ok_len ? 1 + len + 5 : 1)), "R5 R7 cfg write count",
        nw, !ok_size ? 0 : (ok_len ? 1 + len + 5 : 1));
    if (ok_size && nw >= 1) begin
      chk(wlog[0] == 0, "R2 zero byte", wlog[0], 0);
      chk(wcyc[0] - rcyc == ST + 1, "R2 settle gap", wcyc[0] - rcyc, ST + 1);
    end
    if (ok_len && nw == 1 + len + 5) begin
      for (int i = 0; i < len; i++)
        chk(wlog[1 + i] == pay(i, len), "R5 payload byte", wlog[1 + i], pay(i, len));
      for (int i = 0; i < 5; i++)
        chk(wlog[1 + np + i] == 0, "R6 pad byte", wlog[1 + np + i], 0);
    end
    chk(done == ok, "R8 R9 done", done, ok);
    chk(fail == !ok, "R3 R7 R8 fail", fail, !ok);
    chk(ni == (ok ? 2 : 1), "R8 irq write count", ni, ok ? 2 : 1);
    if (ok && ni == 2 && nw >= 6) begin
      chk(ilog[1] == 8'h43, "R9 enable code", ilog[1], 8'h43);
      chk(icyc[1] - wcyc[nw - 1] == ST + 2, "R9 final settle gap",
          icyc[1] - wcyc[nw - 1], ST + 2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail, "R12 reset flags", {busy, done, fail}, 0);
    chk(!cfg_wr && !mem_rd && !tgt_reset && !irq_ctrl_wr, "R12 reset strobes",
        {cfg_wr, mem_rd, tgt_reset, irq_ctrl_wr}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 16; s++) load(s, 3, 0, 0);          // R3
    for (int l = 0; l <= 24; l++) load(16 + l, l, 0, 0);    // R5 R6 R10
    for (int l = 1; l <= 24; l++) load(15 + l, l, 0, 0);    // R7
    load(255, 239, 0, 0);                                   // R4 exact fit
    load(255, 32'h0100_0005, 0, 0);                         // R4 top byte
    load(255, 32'h0001_0000, 0, 0);                         // R4 middle byte
    load(255, 32'h0000_0100, 0, 0);                         // R4 byte 2
    load(40, 4, 1, 0);                                      // R8 error bit
    load(16, 0, 1, 0);                                      // R8 with empty payload
    load(60, 10, 0, 1);                                     // R1 start while busy
    repeat (10) @(negedge clk);
    chk(done == 1 && fail == 0, "R11 done holds", done, 1);
    start = 1; @(negedge clk); start = 0;
    chk(done == 0 && fail == 0, "R11 cleared by start", {done, fail}, 0);
    while (busy) @(negedge clk);
    load(20, 30, 0, 0);
    repeat (10) @(negedge clk);
    chk(fail == 1, "R11 fail holds", fail, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL R1 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule